// File: doc/BRIEF.md
# Scanline-Half Pattern Table Auto-Switch

This block drives the most significant address bit (A12) of an 8 KiB character RAM that holds two 4 KiB pattern tables. When auto mode is off, the RAM's A12 simply follows the video chip's A12. When auto mode is on, every pattern fetch uses a half chosen from where the video chip last read a nametable. The top half of any nametable maps to the left pattern table and the bottom half maps to the right one. This holds whatever the scroll position.

The block works by watching the video chip's A13 line. Each time that line rises (a nametable or attribute access begins), the block captures nametable address bit 9 (top half = 0, bottom half = 1). Later pattern fetches (A13 low) use the captured bit as character A12.

Auto mode is turned on and off by one bit of the bank-low register write. That register's write strobe and data byte reach the block as plain inputs.

Both video bus inputs are taken into the system clock domain through a synchroniser before the rising edge of A13 is detected. The output multiplexer itself works directly on the live pins.

Top module: `chr_auto_switch`

## Requirements
- R1: After reset, auto mode is off, so `chrA12` equals `ppuA12` until auto mode is enabled.
- R2: While auto mode is off, `chrA12` equals `ppuA12` for every value of `ppuA13` and `ppuA9`.
- R3: While auto mode is on and `ppuA13` is 0, `chrA12` equals the value that `ppuA9` had when `ppuA13` last rose. `ppuA9` must be held for `SYNC_STAGES`+2 clock cycles after the rise.
- R4: Changes of `ppuA9` that happen while `ppuA13` stays high (after the capture window) have no effect on the captured bit. Changes while `ppuA13` stays low also have no effect.
- R5: While `ppuA13` is 1, `chrA12` equals `ppuA12` regardless of the mode.
- R6: A cycle with `regWrEn` high loads the auto mode flag from data bit 7 (1 = on, 0 = off). Bits 6..0, including the two low bits that a swap mode may exchange, have no effect on it.
- R7: Clearing auto mode takes effect at the first clock edge after the write. From the next cycle, pattern fetches follow `ppuA12`, even part way through a frame.
- R8: The captured bit resets to 0. It is kept unchanged while auto mode is switched off and on again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| regWrEn | input | 1 | Write strobe for the bank-low register |
| regWrData | input | 8 | Data byte written with the strobe; bit 7 is the auto mode flag |
| ppuA13 | input | 1 | Video chip address bit 13 (1 = nametable access) |
| ppuA12 | input | 1 | Video chip address bit 12 |
| ppuA9 | input | 1 | Video chip address bit 9 (nametable half) |
| chrA12 | output | 1 | A12 driven to the character RAM |

## Verification
The bench targets several corner cases, each with a distinct failure signature:

- **A9 changed after the capture window while A13 is still high.** A design that samples on the level of A13, or on its falling edge, would record the late value.
- **Auto mode enabled with no nametable access since reset.** Pattern fetches must read the reset value 0; an uninitialised or wrongly reset capture would show up here.
- **Auto mode turned off part way through a frame.** The output must follow A12 from the next cycle; a design that latches the mode only at an A13 edge would keep the stale half.
- **Writes with bit 7 clear but the low bits set.** These must leave auto mode off; a design that decodes the wrong bit would turn it on.

// File: rtl/chr_auto_pkg.sv
package chr_auto_pkg;

  // Strobes and samples passed from control to datapath
  typedef struct packed {
    logic capture;    // one-cycle pulse: synchronised A13 just rose
    logic sampledA9;  // A9 aligned with the synchronised A13
    logic autoOn;     // auto mode flag
  } ctrlStrobes_t;

endpackage

// File: rtl/chr_auto_ctrl.sv
module chr_auto_ctrl
  import chr_auto_pkg::*;
#(
  parameter int REG_WIDTH   = 8,
  parameter int ENABLE_BIT  = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_WIDTH-1:0] regWrData,
  input  logic                 ppuA13,
  input  logic                 ppuA9,
  output ctrlStrobes_t         strobes
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncA13;
  logic [SYNC_STAGES-1:0] syncA9;
  logic                   prevA13;
  logic                   autoOn;

  // Synchroniser chain for both bus bits so they stay aligned
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) begin
            syncA13[0] <= 1'b0;
            syncA9[0]  <= 1'b0;
          end else begin
            syncA13[0] <= ppuA13;
            syncA9[0]  <= ppuA9;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) begin
            syncA13[s] <= 1'b0;
            syncA9[s]  <= 1'b0;
          end else begin
            syncA13[s] <= syncA13[s-1];
            syncA9[s]  <= syncA9[s-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevA13 <= 1'b0;
    else       prevA13 <= syncA13[LAST];
  end

  // Mode flag: only the enable bit of the register is decoded here
  always_ff @(posedge clk) begin
    if (!rstN)        autoOn <= 1'b0;
    else if (regWrEn) autoOn <= regWrData[ENABLE_BIT];
  end

  always_comb begin
    strobes.capture   = syncA13[LAST] & ~prevA13;
    strobes.sampledA9 = syncA9[LAST];
    strobes.autoOn    = autoOn;
  end

endmodule

// File: rtl/chr_auto_dp.sv
module chr_auto_dp
  import chr_auto_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic         ppuA13,
  input  logic         ppuA12,
  output logic         heldA9,
  output logic         chrA12
);

  always_ff @(posedge clk) begin
    if (!rstN)                heldA9 <= 1'b0;
    else if (strobes.capture) heldA9 <= strobes.sampledA9;
  end

  // Pattern fetch in auto mode uses the captured half; otherwise pass A12
  always_comb begin
    if (strobes.autoOn && !ppuA13) chrA12 = heldA9;
    else                           chrA12 = ppuA12;
  end

endmodule

// File: rtl/chr_auto_switch.sv
module chr_auto_switch
  import chr_auto_pkg::*;
#(
  parameter int REG_WIDTH   = 8,
  parameter int ENABLE_BIT  = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_WIDTH-1:0] regWrData,
  input  logic                 ppuA13,
  input  logic                 ppuA12,
  input  logic                 ppuA9,
  output logic                 chrA12
);

  ctrlStrobes_t strobes;
  logic         heldA9;

  chr_auto_ctrl #(
    .REG_WIDTH  (REG_WIDTH),
    .ENABLE_BIT (ENABLE_BIT),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .ppuA13   (ppuA13),
    .ppuA9    (ppuA9),
    .strobes  (strobes)
  );

  chr_auto_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .ppuA13 (ppuA13),
    .ppuA12 (ppuA12),
    .heldA9 (heldA9),
    .chrA12 (chrA12)
  );

endmodule

// File: rtl/chr_auto_switch_chk.sv
module chr_auto_switch_chk #(
  parameter int REG_WIDTH  = 8,
  parameter int ENABLE_BIT = 7
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWrEn,
  input logic [REG_WIDTH-1:0] regWrData,
  input logic                 ppuA13,
  input logic                 ppuA12,
  input logic                 chrA12,
  input logic                 captureStb,
  input logic                 sampledA9,
  input logic                 heldA9
);

  // R8
  reset_held_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !heldA9);

  // R4
  held_only_on_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(heldA9) |-> $past(captureStb));

  // R3
  capture_loads_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    captureStb |=> heldA9 == $past(sampledA9));

  // R7
  disable_next_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regWrEn && !regWrData[ENABLE_BIT]) && !ppuA13) |-> chrA12 == ppuA12);

endmodule

bind chr_auto_switch chr_auto_switch_chk #(
  .REG_WIDTH (REG_WIDTH),
  .ENABLE_BIT(ENABLE_BIT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .ppuA13    (ppuA13),
  .ppuA12    (ppuA12),
  .chrA12    (chrA12),
  .captureStb(strobes.capture),
  .sampledA9 (strobes.sampledA9),
  .heldA9    (heldA9)
);

// File: tb/chr_auto_switch_bench.sv
module chr_auto_switch_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic       ppuA13 = 1'b0;
  logic       ppuA12 = 1'b0;
  logic       ppuA9 = 1'b0;
  logic       chrA12;

  int vectors = 0;
  int misses  = 0;
  bit expOn   = 1'b0;
  bit expHeld = 1'b0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chr_auto_switch #(.SYNC_STAGES(SYNC)) u_chr_auto_switch (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .ppuA13(ppuA13), .ppuA12(ppuA12), .ppuA9(ppuA9), .chrA12(chrA12)
  );

  function automatic bit expectA12(bit on, bit held, bit a13, bit a12);
    return (on && !a13) ? held : a12;
  endfunction

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req);
    bit e;
    #1;
    e = expectA12(expOn, expHeld, ppuA13, ppuA12);
    vectors++;
    if (chrA12 !== e) begin
      misses++;
      $display("FAIL %s: chrA12=%0b expected %0b (a13=%0b a12=%0b)",
               req, chrA12, e, ppuA13, ppuA12);
    end
  endtask

  task automatic writeReg(logic [7:0] d);
    regWrEn = 1'b1; regWrData = d;
    cycles(1);
    regWrEn = 1'b0;
    expOn = d[7];
  endtask

  // Nametable access: A13 high with a given half, optional late A9 change
  task automatic ntAccess(bit a9, bit lateFlip);
    ppuA13 = 1'b1; ppuA9 = a9; ppuA12 = 1'($urandom);
    cycles(SYNC + 2);
    expHeld = a9;
    check("R5");
    if (lateFlip) begin
      ppuA9 = ~a9; ppuA12 = ~ppuA12;
      cycles(2);
      check("R4");
    end
    ppuA13 = 1'b0;
    cycles(SYNC + 1);
  endtask

  task automatic patFetch(string req);
    ppuA13 = 1'b0; ppuA12 = 1'($urandom); ppuA9 = 1'($urandom);
    cycles(1);
    check(req);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not end, got hung expected done");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0163));
    cycles(4);
    rstN = 1'b1;
    cycles(1);

    // R1: reset state follows A12
    ppuA12 = 1'b1; cycles(1); check("R1");
    ppuA12 = 1'b0; cycles(1); check("R1");

    // R6: low bits set, bit 7 clear keeps mode off
    writeReg(8'h7F);
    ppuA12 = 1'b1; cycles(1); check("R6");

    // R8: enable with no capture yet -> held is 0
    writeReg(8'h80);
    ppuA12 = 1'b1; cycles(1); check("R8");

    // R3: capture bottom half
    ntAccess(1'b1, 1'b0);
    ppuA12 = 1'b0; cycles(1); check("R3");

    // R4: late A9 change while A13 high is ignored
    ntAccess(1'b0, 1'b1);
    ppuA12 = 1'b1; ppuA9 = 1'b1; cycles(1); check("R4");

    // R7: disable mid-frame, next cycle follows A12
    writeReg(8'h03);
    ppuA12 = 1'b1; cycles(1); check("R7");
    ppuA12 = 1'b0; cycles(1); check("R2");

    // R8: held bit survives off/on toggle
    ntAccess(1'b1, 1'b0);
    writeReg(8'h80);
    ppuA12 = 1'b0; cycles(1); check("R8");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 3));
      case (op)
        0: writeReg(8'($urandom));
        1: ntAccess(1'($urandom), 1'($urandom));
        default: patFetch(expOn ? "R3" : "R2");
      endcase
    end

    done = 1'b1;
    finishRun();
  end

endmodule